// File: doc/BRIEF.md
# Prioritised Interrupt Acknowledge Controller

This block resolves eight active-low interrupt request lines into a single priority level and decides whether the processor should take it. The decision compares the level against the mask field of the status word. When the request is accepted, the block runs an acknowledge cycle. During that cycle a device returns its vector number on a vector bus qualified by a valid strobe.

The acknowledged level is captured when the cycle starts and held until the cycle ends. The block resolves the vector number in one of three ways:

- It passes on the number the device supplied.
- It maps the uninitialised-device code to the uninitialised-interrupt vector.
- It returns the spurious-interrupt vector when no device answers within a fixed number of clocks. This stops the processor from hanging.

When a cycle completes, the mask field is raised to the acknowledged level. The mask can also be loaded from a full status word through a write strobe.

Top module: `irq_ack_ctrl`

## Requirements
- R1: `level_o` is the highest index k in 1..7 for which `irq_ni[k]` is 0. If no such line is low, `level_o` is 0. Line 0 never contributes a level.
- R2: Outside an acknowledge cycle, `pending_o` is 1 exactly when `level_o` is nonzero and either `level_o` is greater than `mask_o` or `level_o` equals 7. Level 7 is accepted even when the mask is 7.
- R3: If `pending_o` is 1 at a rising clock edge, then from the next cycle `iack_o` is 1 and `iack_level_o` equals the level seen at that edge. `iack_level_o` stays constant for the whole cycle whatever the request lines do.
- R4: If `vec_valid_i` is 1 at an edge during the cycle and `vec_i` is not 0x0F, then in the next cycle `vector_o` equals `vec_i`, `vector_valid_o` is 1 for exactly one cycle, and `iack_o` is 0.
- R5: A device answer of 0x0F resolves to vector 15, the uninitialised-interrupt vector.
- R6: `iack_o` stays high for 16 cycles when no valid answer arrives. In the cycle after those 16, `vector_o` is 24, `vector_valid_o` is 1 and `iack_o` is 0. A valid answer at the edge ending the 16th cycle takes precedence over the timeout.
- R7: Every completed acknowledge cycle, including uninitialised and spurious ones, sets `mask_o` to the acknowledged level. The new mask is visible in the same cycle as `vector_valid_o`.
- R8: `status_we_i` loads `mask_o` from `status_i[10:8]`, and the other status bits have no effect. If a completion happens at the same edge, the completion update wins.
- R9: After reset, `iack_o`, `vector_valid_o` and `vector_o` are 0, and `mask_o` is 7.
- R10: `vec_valid_i` outside an acknowledge cycle has no effect: `vector_valid_o` stays 0.
- R11: `pending_o` is 0 while an acknowledge cycle is in progress, even if line 7 is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_ni | input | 8 | Interrupt request lines, active low, index is priority |
| status_i | input | 16 | Status word; bits 10:8 carry the mask |
| status_we_i | input | 1 | Load mask from status word |
| vec_i | input | 8 | Vector number returned by the device |
| vec_valid_i | input | 1 | Qualifies vec_i during acknowledge |
| level_o | output | 3 | Encoded request level |
| pending_o | output | 1 | Request accepted against the mask |
| iack_o | output | 1 | Acknowledge cycle in progress |
| iack_level_o | output | 3 | Level being acknowledged |
| vector_o | output | 8 | Resolved vector number |
| vector_valid_o | output | 1 | One-cycle strobe for vector_o |
| mask_o | output | 3 | Current mask level |

## Verification
Every request pattern is swept against every mask value. This catches an encoder that lets line 0 or a lower line win. It also catches a comparator that accepts a level equal to the mask, or that refuses level 7 under mask 7.

Acknowledge cycles are run at each level with answer delays from zero up to the last cycle before timeout. A valid answer on that last cycle must beat the spurious path; an off-by-one counter would return vector 24 there or cut the cycle short. Requests are changed mid-cycle, so a design that does not latch the level shows a changed `iack_level_o` or a false pending flag.

The 0x0F code, a status write colliding with completion, and a stray valid strobe while idle are each driven. These expose a missing remap, a lost mask update and a phantom vector strobe.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_ACK  = 1'b1
  } ack_state_e;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N_LINES = 8,
  localparam int LW = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] req_ni,
  output logic [LW-1:0]      level_o
);
  // line 0 encodes "no request"
  always_comb begin
    level_o = '0;
    for (int k = 1; k < N_LINES; k++) begin
      if (!req_ni[k]) level_o = LW'(k);
    end
  end

  always_comb begin
    if (!req_ni[N_LINES-1])
      a_top_line_r1: assert (level_o == LW'(N_LINES-1));
  end
endmodule

// File: rtl/irq_pend_cmp.sv
module irq_pend_cmp #(
  parameter int LW = 3
) (
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] mask_i,
  input  logic          busy_i,
  output logic          pending_o
);
  localparam logic [LW-1:0] LVL_MAX = '1;

  logic above;
  assign above     = (level_i > mask_i) || (level_i == LVL_MAX);
  assign pending_o = !busy_i && (level_i != '0) && above;

  always_comb begin
    if (level_i == '0)
      a_zero_idle_r2: assert (!pending_o);
  end
endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
  import irq_ack_pkg::*;
#(
  parameter int          LW          = 3,
  parameter int          VW          = 8,
  parameter int          TIMEOUT     = 16,
  parameter logic [VW-1:0] UNINIT_CODE = 8'h0F,
  parameter logic [VW-1:0] UNINIT_VEC  = 8'd15,
  parameter logic [VW-1:0] SPUR_VEC    = 8'd24,
  localparam int         CW          = $clog2(TIMEOUT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pending_i,
  input  logic [LW-1:0] level_i,
  input  logic [VW-1:0] vec_i,
  input  logic          vec_valid_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [LW-1:0] iack_level_o,
  output logic [VW-1:0] vector_o,
  output logic          vector_valid_o
);
  ack_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [LW-1:0] lvl_q;
  logic          expired;
  logic [VW-1:0] resolved;

  assign expired  = (cnt_q == CW'(TIMEOUT - 1));
  assign resolved = (vec_i == UNINIT_CODE) ? UNINIT_VEC : vec_i;
  assign busy_o   = (state_q == ST_ACK);
  assign done_o   = busy_o && (vec_valid_i || expired);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= ST_IDLE;
      cnt_q          <= '0;
      lvl_q          <= '0;
      vector_o       <= '0;
      vector_valid_o <= 1'b0;
    end else begin
      vector_valid_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (pending_i) begin
            state_q <= ST_ACK;
            lvl_q   <= level_i;
            cnt_q   <= '0;
          end
        end
        ST_ACK: begin
          if (vec_valid_i) begin
            // device answer wins over an expiring timer
            state_q        <= ST_IDLE;
            vector_o       <= resolved;
            vector_valid_o <= 1'b1;
          end else if (expired) begin
            state_q        <= ST_IDLE;
            vector_o       <= SPUR_VEC;
            vector_valid_o <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign iack_level_o = busy_o ? lvl_q : '0;

  p_lvl_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> $stable(iack_level_o));
  p_lvl_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> iack_level_o != '0);
  p_no_overflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> cnt_q < CW'(TIMEOUT));
  p_vv_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_valid_o |=> !vector_valid_o);
  p_idle_no_vv_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> !vector_valid_o);
endmodule

// File: rtl/irq_ack_ctrl.sv
module irq_ack_ctrl #(
  parameter int N_LINES  = 8,
  parameter int SR_W     = 16,
  parameter int MASK_LSB = 8,
  parameter int VW       = 8,
  parameter int TIMEOUT  = 16,
  localparam int LW      = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] irq_ni,
  input  logic [SR_W-1:0]    status_i,
  input  logic               status_we_i,
  input  logic [VW-1:0]      vec_i,
  input  logic               vec_valid_i,
  output logic [LW-1:0]      level_o,
  output logic               pending_o,
  output logic               iack_o,
  output logic [LW-1:0]      iack_level_o,
  output logic [VW-1:0]      vector_o,
  output logic               vector_valid_o,
  output logic [LW-1:0]      mask_o
);
  logic [LW-1:0] mask_q;
  logic          busy;
  logic          done;

  irq_prio_enc #(.N_LINES(N_LINES)) u_enc (
    .req_ni  (irq_ni),
    .level_o (level_o)
  );

  irq_pend_cmp #(.LW(LW)) u_cmp (
    .level_i   (level_o),
    .mask_i    (mask_q),
    .busy_i    (busy),
    .pending_o (pending_o)
  );

  irq_ack_fsm #(.LW(LW), .VW(VW), .TIMEOUT(TIMEOUT)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .pending_i      (pending_o),
    .level_i        (level_o),
    .vec_i          (vec_i),
    .vec_valid_i    (vec_valid_i),
    .busy_o         (busy),
    .done_o         (done),
    .iack_level_o   (iack_level_o),
    .vector_o       (vector_o),
    .vector_valid_o (vector_valid_o)
  );

  // completion raises the mask and takes priority over a status write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          mask_q <= '1;
    else if (done)        mask_q <= iack_level_o;
    else if (status_we_i) mask_q <= status_i[MASK_LSB +: LW];
  end

  assign iack_o = busy;
  assign mask_o = mask_q;

  p_mask_follow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vector_valid_o |-> mask_o == $past(iack_level_o));
  p_no_pend_busy_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iack_o |-> !pending_o);
endmodule

// File: tb/irq_ack_ctrl_bench.sv
`timescale 1ns/1ps
module irq_ack_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  irq_n = 8'hFF;
  logic [15:0] status = '0;
  logic        status_we = 1'b0;
  logic [7:0]  vec = '0;
  logic        vec_valid = 1'b0;
  logic [2:0]  level, iack_level, mask;
  logic        pending, iack, vv;
  logic [7:0]  vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_ack_ctrl u_irq_ack_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .irq_ni(irq_n), .status_i(status),
    .status_we_i(status_we), .vec_i(vec), .vec_valid_i(vec_valid),
    .level_o(level), .pending_o(pending), .iack_o(iack),
    .iack_level_o(iack_level), .vector_o(vector), .vector_valid_o(vv),
    .mask_o(mask)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_mask(input int m);
    @(negedge clk);
    status    = 16'hF8FF ^ 16'h0500;
    status[10:8] = m[2:0];
    status_we = 1'b1;
    @(negedge clk);
    status_we = 1'b0;
    status    = '0;
    chk(mask == m[2:0], "R8 mask load", mask, m);
  endtask

  task automatic run_ack(input int lvl, input int m, input int d, input int v,
                         input bit tmo, input bit clash);
    int exp_v;
    set_mask(m);
    irq_n = ~8'((2 << lvl) - 1);
    @(negedge clk);
    chk(iack == 1'b1, "R3 iack start", iack, 1);
    chk(iack_level == lvl[2:0], "R3 iack level", iack_level, lvl);
    chk(pending == 1'b0, "R11 no pending in ack", pending, 0);
    irq_n = (d > 0 || tmo) ? 8'h7F : 8'hFF;
    if (tmo) begin
      for (int k = 1; k < 16; k++) begin
        @(negedge clk);
        chk(iack == 1'b1, "R6 iack held", iack, 1);
        if (k == 1) begin
          chk(pending == 1'b0, "R11 line7 in ack", pending, 0);
          chk(iack_level == lvl[2:0], "R3 level hold", iack_level, lvl);
          irq_n = 8'hFF;
        end
      end
      @(negedge clk);
      chk(iack == 1'b0, "R6 iack end", iack, 0);
      chk(vv == 1'b1, "R6 vv", vv, 1);
      chk(vector == 8'd24, "R6 spurious vector", vector, 24);
      chk(mask == lvl[2:0], "R7 mask after timeout", mask, lvl);
    end else begin
      for (int k = 1; k <= d; k++) begin
        @(negedge clk);
        chk(iack == 1'b1, "R3 iack held", iack, 1);
        if (k == 1) begin
          chk(pending == 1'b0, "R11 line7 in ack", pending, 0);
          chk(iack_level == lvl[2:0], "R3 level hold", iack_level, lvl);
          irq_n = 8'hFF;
        end
      end
      vec_valid = 1'b1;
      vec = v[7:0];
      if (clash) begin
        status_we = 1'b1;
        status = 16'h0000;
      end
      @(negedge clk);
      vec_valid = 1'b0;
      status_we = 1'b0;
      exp_v = (v == 8'h0F) ? 15 : v;
      chk(iack == 1'b0, "R4 iack end", iack, 0);
      chk(vv == 1'b1, "R4 vv", vv, 1);
      if (v == 8'h0F) chk(vector == 8'(exp_v), "R5 uninit vector", vector, exp_v);
      else            chk(vector == 8'(exp_v), "R4 device vector", vector, exp_v);
      chk(mask == lvl[2:0], clash ? "R8 completion wins" : "R7 mask update", mask, lvl);
    end
    @(negedge clk);
    chk(vv == 1'b0, "R4 vv one cycle", vv, 0);
  endtask

  initial begin
    int lv, ep;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(iack == 1'b0, "R9 iack reset", iack, 0);
    chk(vv == 1'b0, "R9 vv reset", vv, 0);
    chk(vector == 8'd0, "R9 vector reset", vector, 0);
    chk(mask == 3'd7, "R9 mask reset", mask, 7);

    // R1/R2 sweep: every pattern against every mask, removed before the edge
    for (int m = 0; m < 8; m++) begin
      set_mask(m);
      for (int p = 0; p < 256; p++) begin
        @(negedge clk);
        irq_n = ~8'(p);
        lv = 0;
        for (int k = 1; k < 8; k++) if (p[k]) lv = k;
        ep = (lv != 0 && (lv > m || lv == 7)) ? 1 : 0;
        #1;
        chk(level == 3'(lv), "R1 encode", level, lv);
        chk(pending == ep[0], "R2 pending", pending, ep);
        #1 irq_n = 8'hFF;
      end
    end
    @(negedge clk);
    chk(iack == 1'b0, "R2 no ack from sweep", iack, 0);

    // R10: stray valid while idle
    vec_valid = 1'b1; vec = 8'h55;
    @(negedge clk);
    vec_valid = 1'b0;
    @(negedge clk);
    chk(vv == 1'b0, "R10 idle valid ignored", vv, 0);
    chk(iack == 1'b0, "R10 no ack", iack, 0);

    // level equal to mask is not taken
    set_mask(3);
    irq_n = ~8'h08;
    @(negedge clk);
    chk(iack == 1'b0, "R2 equal not taken", iack, 0);
    irq_n = 8'hFF;

    for (int l = 1; l < 8; l++)
      run_ack(l, (l == 7) ? 7 : l - 1, l % 4, 8'h40 + l, 1'b0, 1'b0);
    run_ack(4, 0, 1, 8'h0F, 1'b0, 1'b0);
    run_ack(2, 1, 0, 0, 1'b1, 1'b0);
    run_ack(7, 7, 0, 0, 1'b1, 1'b0);
    run_ack(6, 3, 15, 8'h99, 1'b0, 1'b0);
    run_ack(5, 2, 3, 8'h81, 1'b0, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule